// File: doc/BRIEF.md
# Dithered Crystal Trim Sequencer

This block steers a crystal oscillator's load-capacitance trim by switching between two fixed 4-bit codes, one that pulls the oscillator slightly slow and one that pulls it slightly fast. Time is divided into frames of a fixed number of timer half-cycle events. Within each frame, the slow code is driven first. At a programmable split point the output changes to the fast code. The fraction of each frame spent at each code sets the average oscillator frequency, at a resolution much finer than either code gives alone.

The split point is closed-loop. At every frame boundary, a phase comparator outside the block reports whether the local clock runs ahead of or behind a reference. The block then moves the split point by one event: toward more slow time when the clock is fast, and toward more fast time when it is slow. The new split point applies from the first event of the next frame. The current split point can be read back at all times.

Top module: `trim_dither_seq`

## Requirements
- R1: The frame position advances by exactly one on each clock cycle in which `half_strobe` is 1, and holds in every other cycle. The trim output therefore changes only in a cycle that follows a strobe.
- R2: The frame position counts 0 to FRAME_LEN-1 (default 1000 events) and returns to 0 on the strobe that follows position FRAME_LEN-1.
- R3: While the frame position is below the threshold, `trim_code` is the slow code, binary 0010.
- R4: While the frame position is at or above the threshold, `trim_code` is the fast code, binary 1100. A threshold of 0 gives the fast code for a whole frame. A threshold of FRAME_LEN gives the slow code for a whole frame.
- R5: On the strobe that ends a frame, if `phase_fast` is 1 and `phase_slow` is 0, the threshold rises by 1. It saturates at FRAME_LEN.
- R6: On the strobe that ends a frame, if `phase_slow` is 1 and `phase_fast` is 0, the threshold falls by 1. It saturates at 0.
- R7: The threshold does not change when both phase inputs are equal, or on any cycle that is not a frame-ending strobe, whatever the phase inputs are then.
- R8: After reset, the threshold reads 500 (THR_INIT), the frame position is 0, and `trim_code` is the slow code 0010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| half_strobe | input | 1 | One timer half-cycle event per cycle in which it is 1 |
| phase_fast | input | 1 | Comparator reports local clock ahead of reference |
| phase_slow | input | 1 | Comparator reports local clock behind reference |
| trim_code | output | 4 | Load-capacitance trim code to the oscillator |
| threshold | output | CNT_W (10) | Current split point, readback |

## Verification
The assertions take the phase inputs to be meaningful only in the cycle of a frame-ending strobe. They check that the inputs have no effect at any other time. They also rely on `half_strobe` counting one event for each cycle it is high. The stimulus raises the strobe for single cycles separated by idle cycles, and it changes all inputs on the falling edge, so each event is counted once. The phase inputs are held at every combination, including both high, across frame boundaries and idle gaps. A second, short-frame instance drives the threshold into both saturation limits within the run.

// File: rtl/trim_dither_pkg.sv
package trim_dither_pkg;
    // Default trim codes: slow-pulling and fast-pulling load settings.
    localparam logic [3:0] SLOW_CODE_DEF = 4'b0010;
    localparam logic [3:0] FAST_CODE_DEF = 4'b1100;

    // Direction decided by the loop filter at a frame boundary.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_dir_e;
endpackage

// File: rtl/dts_frame_counter.sv
// Frame position counter.
// Counts timer half-cycle events from 0 to FRAME_LEN-1 and wraps to 0.
// Assumes: strobe is synchronous to clk, one event per high cycle.
module dts_frame_counter #(
    parameter int unsigned FRAME_LEN = 1000,
    parameter int unsigned CNT_W     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    // Flag the event that closes the current frame.
    always_comb wrap = strobe && (count == LAST);

    // Advance on each event, return to zero after the last position.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (strobe)
            count <= wrap ? '0 : count + 1'b1;
    end

    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST);
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && count == LAST) |=> (count == '0));
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && count != LAST) |=> (count == $past(count) + 1'b1));
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(count));
endmodule

// File: rtl/dts_thr_filter.sv
// Loop filter for the dither split point.
// Moves the threshold by one at each frame boundary, according to the
// phase direction, and saturates within 0..FRAME_LEN.
// Assumes: phase inputs are sampled only in the frame-ending cycle.
module dts_thr_filter
    import trim_dither_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 1000,
    parameter int unsigned CNT_W     = 10,
    parameter int unsigned THR_INIT  = 500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic             phase_fast,
    input  logic             phase_slow,
    output logic [CNT_W-1:0] thr
);
    localparam logic [CNT_W-1:0] THR_MAX   = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] THR_RESET = CNT_W'(THR_INIT);

    step_dir_e dir;

    // Decode the comparator outputs into a step direction.
    always_comb begin
        if (phase_fast && !phase_slow)
            dir = STEP_UP;
        else if (phase_slow && !phase_fast)
            dir = STEP_DOWN;
        else
            dir = STEP_HOLD;
    end

    // Apply one saturating step per frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr <= THR_RESET;
        else if (wrap) begin
            case (dir)
                STEP_UP:   if (thr != THR_MAX) thr <= thr + 1'b1;
                STEP_DOWN: if (thr != '0)      thr <= thr - 1'b1;
                default:   thr <= thr;
            endcase
        end
    end

    p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        thr <= THR_MAX);
    p_only_at_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(thr));
    p_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && phase_fast && !phase_slow && thr != THR_MAX)
        |=> (thr == $past(thr) + 1'b1));
    p_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && phase_slow && !phase_fast && thr != '0)
        |=> (thr == $past(thr) - 1'b1));
    p_equal_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_fast == phase_slow) |=> $stable(thr));
endmodule

// File: rtl/dts_code_select.sv
// Trim code selector.
// Drives the slow code below the threshold and the fast code from it on.
// Assumes: count and thr come from registers, so the output is glitch-free
// at the clock edge.
module dts_code_select #(
    parameter int unsigned CNT_W     = 10,
    parameter int unsigned CODE_W    = 4,
    parameter logic [CODE_W-1:0] SLOW_CODE = 4'b0010,
    parameter logic [CODE_W-1:0] FAST_CODE = 4'b1100
) (
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  thr,
    output logic [CODE_W-1:0] code
);
    // Choose the trim code for the current frame position.
    always_comb code = (count < thr) ? SLOW_CODE : FAST_CODE;
endmodule

// File: rtl/trim_dither_seq.sv
// Dithered crystal trim sequencer, top level.
// Time-shares the trim output between a slow and a fast code within each
// frame of half-cycle events, with a split point closed by a phase loop.
// Assumes: phase_fast/phase_slow are valid in the frame-ending strobe cycle.
module trim_dither_seq
    import trim_dither_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 1000,
    parameter int unsigned THR_INIT  = 500,
    parameter int unsigned CODE_W    = 4,
    parameter logic [CODE_W-1:0] SLOW_CODE = SLOW_CODE_DEF,
    parameter logic [CODE_W-1:0] FAST_CODE = FAST_CODE_DEF,
    localparam int unsigned CNT_W    = $clog2(FRAME_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_strobe,
    input  logic              phase_fast,
    input  logic              phase_slow,
    output logic [CODE_W-1:0] trim_code,
    output logic [CNT_W-1:0]  threshold
);
    logic [CNT_W-1:0] frame_pos;
    logic             frame_end;

    dts_frame_counter #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (half_strobe),
        .count  (frame_pos),
        .wrap   (frame_end)
    );

    dts_thr_filter #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W), .THR_INIT(THR_INIT)) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap       (frame_end),
        .phase_fast (phase_fast),
        .phase_slow (phase_slow),
        .thr        (threshold)
    );

    dts_code_select #(.CNT_W(CNT_W), .CODE_W(CODE_W),
                      .SLOW_CODE(SLOW_CODE), .FAST_CODE(FAST_CODE)) u_sel (
        .count (frame_pos),
        .thr   (threshold),
        .code  (trim_code)
    );

    p_code_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !half_strobe |=> $stable(trim_code));
    p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_code == SLOW_CODE) || (trim_code == FAST_CODE));
    p_full_slow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (threshold == CNT_W'(FRAME_LEN)) |-> (trim_code == SLOW_CODE));
    p_reset_r8: assert property (@(posedge clk)
        !rst_n |=> (threshold == CNT_W'(THR_INIT) && frame_pos == '0));
endmodule

// File: tb/tb_trim_dither_seq.sv
module tb_trim_dither_seq;
    localparam int CLK_PERIOD = 10;
    localparam int M_LEN = 1000, M_INIT = 500;
    localparam int S_LEN = 12,   S_INIT = 6;
    localparam logic [3:0] SLOW = 4'b0010, FAST = 4'b1100;

    logic clk = 0, rst_n = 0, half_strobe = 0, phase_fast = 0, phase_slow = 0;
    logic [3:0] m_code, s_code;
    logic [9:0] m_thr;
    logic [3:0] s_thr;

    int checks = 0, errors = 0;
    int m_cnt, m_tv, s_cnt, s_tv;

    always #(CLK_PERIOD/2) clk = ~clk;

    trim_dither_seq dut (
        .clk(clk), .rst_n(rst_n), .half_strobe(half_strobe),
        .phase_fast(phase_fast), .phase_slow(phase_slow),
        .trim_code(m_code), .threshold(m_thr));

    trim_dither_seq #(.FRAME_LEN(S_LEN), .THR_INIT(S_INIT)) dut_short (
        .clk(clk), .rst_n(rst_n), .half_strobe(half_strobe),
        .phase_fast(phase_fast), .phase_slow(phase_slow),
        .trim_code(s_code), .threshold(s_thr));

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Compare both instances against the bench models.
    task automatic check_all(input string ttag);
        chk((m_cnt < m_tv) ? "R3 main code" : "R4 main code", m_code, (m_cnt < m_tv) ? SLOW : FAST);
        chk((s_cnt < s_tv) ? "R3 short code" : "R4 short code", s_code, (s_cnt < s_tv) ? SLOW : FAST);
        chk({ttag, " main thr"}, m_thr, m_tv);
        chk({ttag, " short thr"}, s_thr, s_tv);
    endtask

    function automatic int step(input int tv, input int len, input bit f, input bit s);
        if (f && !s && tv < len) return tv + 1;
        if (s && !f && tv > 0)   return tv - 1;
        return tv;
    endfunction

    // One strobe event with the given phase inputs, then check.
    task automatic tick(input bit f, input bit s, input string ttag);
        @(negedge clk);
        half_strobe = 1; phase_fast = f; phase_slow = s;
        @(negedge clk);
        half_strobe = 0;
        if (m_cnt == M_LEN - 1) begin m_cnt = 0; m_tv = step(m_tv, M_LEN, f, s); end
        else m_cnt++;
        if (s_cnt == S_LEN - 1) begin s_cnt = 0; s_tv = step(s_tv, S_LEN, f, s); end
        else s_cnt++;
        check_all(ttag);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        m_cnt = 0; m_tv = M_INIT; s_cnt = 0; s_tv = S_INIT;
        chk("R8 main thr", m_thr, M_INIT);
        chk("R8 main code", m_code, SLOW);
        chk("R8 short thr", s_thr, S_INIT);
        chk("R8 short code", s_code, SLOW);
    endtask

    // No strobe: phase inputs and time must not move anything.
    task automatic t_idle();
        for (int i = 0; i < 4; i++) begin
            phase_fast = i[0]; phase_slow = i[1];
            repeat (5) @(negedge clk);
            check_all("R7 idle");
            chk("R1 idle main code", m_code, (m_cnt < m_tv) ? SLOW : FAST);
        end
        phase_fast = 0; phase_slow = 0;
    endtask

    // A whole main frame with neutral phase; code flips at 500, wraps back.
    task automatic t_neutral_frame();
        for (int i = 0; i < M_LEN; i++) tick(0, 0, "R7 neutral");
        chk("R2 main wrap code", m_code, SLOW);
        chk("R2 main wrap thr", m_thr, M_INIT);
    endtask

    task automatic t_both();
        for (int i = 0; i < S_LEN; i++) tick(1, 1, "R7 both");
        chk("R7 short both thr", s_thr, S_INIT);
    endtask

    task automatic t_fast_sat();
        for (int i = 0; i < 100; i++) tick(1, 0, "R5 fast");
        chk("R5 short saturate", s_thr, S_LEN);
        chk("R4 short full slow", s_code, SLOW);
    endtask

    task automatic t_slow_sat();
        for (int i = 0; i < 200; i++) tick(0, 1, "R6 slow");
        chk("R6 short saturate", s_thr, 0);
        chk("R4 short all fast", s_code, FAST);
    endtask

    // Steer the main threshold at its own frame boundaries.
    task automatic t_main_steer();
        while (m_cnt != M_LEN - 1) tick(0, 0, "R7 approach");
        tick(1, 0, "R5 main wrap");
        chk("R5 main up", m_thr, M_INIT + 1);
        while (m_cnt != M_LEN - 1) tick(0, 0, "R7 approach");
        tick(0, 1, "R6 main wrap");
        chk("R6 main down", m_thr, M_INIT);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_neutral_frame();
        t_both();
        t_fast_sat();
        t_slow_sat();
        t_idle();
        t_main_steer();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule